// File: doc/BRIEF.md
# Auxiliary Channel Preemphasis Filter with Output Limiter

This block conditions one stereo sample pair before it goes to an external modulator. The left sample passes through untouched. The right sample is attenuated by about 3 dB and then, depending on a two-bit mode input, passed through a first-order high-frequency boost that uses either a 50 µs or a 75 µs time constant. The boost gain at high frequencies is above the 3 dB of attenuation, so a full-scale input can still overshoot. A saturating stage clamps the result to the largest positive or negative 16-bit code and never wraps.

Samples arrive with a one-cycle valid strobe at a nominal 48 kHz rate, and the coefficients are fixed for that rate. Each accepted sample produces exactly one output strobe two clock cycles later, in every mode. When the mode code of a sample differs from that of the previous sample, the filter history is treated as zero for that sample, so that stale history from the old mode cannot cause a transient.

Top module: `aux_preemph`

## Requirements
- R1: Mode encoding: 2'b00 is off, 2'b01 selects the 50 µs filter, 2'b10 selects the 75 µs filter, and 2'b11 is reserved and behaves exactly like off.
- R2: The right input x is first scaled to s = floor(x * 23170 / 32768), with the floor taken toward minus infinity, giving a 16-bit signed result.
- R3: In the filtering modes the right output is y = sat(floor((b0*s + b1*s1 + f*y1) / 16384)). Here s1 is the previous scaled sample, y1 is the previous right output, and (b0, b1, f) is (31249, -20599, 5734) for 50 µs and (30403, -23030, 9011) for 75 µs.
- R4: sat() clamps to 32767 above and to -32768 below, and passes other values through unchanged. An overshoot never wraps around.
- R5: In the off modes the right output equals s, with the same latency as the filtering modes. That output also becomes y1 for the next sample.
- R6: The left output equals the left input of the same sample, unmodified.
- R7: If a sample's mode code differs from the mode code of the previous accepted sample, then s1 and y1 are taken as zero for that sample. After reset, the previous mode code is 2'b00.
- R8: out_valid is high for exactly one cycle, two clock cycles after each cycle in which in_valid is high, and the outputs hold their values between strobes.
- R9: While rst_n is low at a clock edge, out_valid, out_left and out_right become 0, the filter history is cleared, and the previous mode code is set to 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_left | input | 16 | Left input sample, signed |
| in_right | input | 16 | Right input sample, signed |
| mode | input | 2 | Preemphasis mode select |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | 16 | Left output sample, signed |
| out_right | output | 16 | Right output sample, conditioned and limited |

## Verification
A wrong coefficient, a wrong rounding choice or corrupted history shows up at out_right on the very next output strobe. Because the filter is recursive, the error then persists in every later filtered sample until a mode change clears the history. A failed history clear is visible on the first sample after the mode switch. A failed clamp shows up as a sign flip on the first full-scale step. A latency error moves out_valid by at least one cycle and shows up on the first sample.

// File: rtl/aux_preemph_pkg.sv
// Package: shared mode encoding and fixed coefficient sets for the
// auxiliary-channel preemphasis filter. The coefficients are computed
// offline for a 48 kHz sample rate, in signed Q2.14 format.
package aux_preemph_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_50US = 2'b01,
        MODE_75US = 2'b10,
        MODE_RSVD = 2'b11
    } pe_mode_e;

    localparam int COEF_W    = 16;
    localparam int COEF_FRAC = 14;

    // Each coefficient set: feedforward b0, b1 and feedback f (f = -a1).
    typedef struct packed {
        logic [COEF_W-1:0] b0;
        logic [COEF_W-1:0] b1;
        logic [COEF_W-1:0] fb;
    } coef_set_t;

    // Returns the coefficient set for a mode. The off modes get zeros.
    function automatic coef_set_t coef_for(pe_mode_e m);
        coef_set_t c;
        case (m)
            MODE_50US: begin
                c.b0 = 16'(31249);
                c.b1 = 16'(-20599);
                c.fb = 16'(5734);
            end
            MODE_75US: begin
                c.b0 = 16'(30403);
                c.b1 = 16'(-23030);
                c.fb = 16'(9011);
            end
            default: begin
                c.b0 = '0;
                c.b1 = '0;
                c.fb = '0;
            end
        endcase
        return c;
    endfunction

    // True for modes that run the filter; reserved behaves as off.
    function automatic logic is_filtering(pe_mode_e m);
        return (m == MODE_50US) || (m == MODE_75US);
    endfunction

endpackage

// File: rtl/aux_preemph_sat.sv
// Saturator: narrows a wide signed value to OUT_W bits, clamping to the
// largest or smallest representable code instead of wrapping.
// Assumes IN_W > OUT_W. Purely combinational.
module aux_preemph_sat #(
    parameter int IN_W  = 34,
    parameter int OUT_W = 16
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);
    localparam int TOP_W = IN_W - OUT_W + 1;

    logic [TOP_W-1:0] top_bits;
    logic             fits;

    assign top_bits = din[IN_W-1:OUT_W-1];

    // The value fits when all discarded bits equal the sign bit.
    assign fits = (top_bits == {TOP_W{1'b0}}) || (top_bits == {TOP_W{1'b1}});

    // Select a pass-through or a clamp to the positive or negative limit.
    always_comb begin
        if (fits)
            dout = din[OUT_W-1:0];
        else if (din[IN_W-1])
            dout = {1'b1, {(OUT_W-1){1'b0}}};
        else
            dout = {1'b0, {(OUT_W-1){1'b1}}};
    end

endmodule

// File: rtl/aux_preemph_scale.sv
// Stage 1: registers each accepted sample pair. It scales the right sample
// by GAIN / 2**GAIN_FRAC (about -3 dB) with a floor, and captures the left
// sample and the mode unchanged. Assumes GAIN < 2**GAIN_FRAC, so the
// result always fits in DATA_W bits.
module aux_preemph_scale #(
    parameter int DATA_W    = 16,
    parameter int GAIN_W    = 16,
    parameter int GAIN      = 23170,
    parameter int GAIN_FRAC = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              v_in,
    input  logic [DATA_W-1:0] x_left,
    input  logic [DATA_W-1:0] x_right,
    input  logic [1:0]        mode_in,
    output logic              v_out,
    output logic [DATA_W-1:0] left_out,
    output logic [DATA_W-1:0] s_out,
    output logic [1:0]        mode_out
);
    localparam int PROD_W = DATA_W + GAIN_W + 1;
    localparam logic [GAIN_W:0] GAIN_V = (GAIN_W+1)'(GAIN);

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] prod_sh;
    logic                     unused_prod;

    assign prod    = $signed(x_right) * $signed(GAIN_V);
    assign prod_sh = prod >>> GAIN_FRAC;
    assign unused_prod = ^prod_sh[PROD_W-1:DATA_W];

    // Strobe pipeline: one cycle of delay for the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) v_out <= 1'b0;
        else        v_out <= v_in;
    end

    // Data capture: load scaled right, raw left and mode on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_out <= '0;
            s_out    <= '0;
            mode_out <= 2'b00;
        end else if (v_in) begin
            left_out <= x_left;
            s_out    <= prod_sh[DATA_W-1:0];
            mode_out <= mode_in;
        end
    end

    // R2: the scaled value keeps the sign of the input (a floor of a
    // negative value stays negative).
    // R2
    scale_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_in |=> (s_out[DATA_W-1] == $past(x_right[DATA_W-1])));

endmodule

// File: rtl/aux_preemph_iir.sv
// Stage 2: first-order shelving IIR with a saturating output.
// y = sat((b0*s + b1*s1 + f*y1) >>> COEF_FRAC) in the filtering modes, and
// y = s in the off modes. History (s1, y1) is treated as zero for a sample
// whose mode differs from the previous sample's mode. Assumes the
// coefficients come from aux_preemph_pkg.
module aux_preemph_iir
    import aux_preemph_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              v_in,
    input  logic [DATA_W-1:0] s_in,
    input  logic [1:0]        mode_in,
    output logic              v_out,
    output logic [DATA_W-1:0] y_out
);
    localparam int PROD_W = DATA_W + COEF_W;
    localparam int ACC_W  = PROD_W + 2;
    localparam int SH_W   = ACC_W - COEF_FRAC;
    localparam logic signed [DATA_W-1:0] MAXV = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] MINV = {1'b1, {(DATA_W-1){1'b0}}};

    pe_mode_e           cur_mode;
    coef_set_t          coefs;
    logic               filt;
    logic               clr;
    logic [1:0]         last_mode;
    logic [DATA_W-1:0]  s1_q, y1_q;
    logic [DATA_W-1:0]  s1_use, y1_use;
    logic signed [PROD_W-1:0] p0, p1, p2;
    logic signed [ACC_W-1:0]  acc;
    logic [DATA_W-1:0]  y_lim;
    logic [DATA_W-1:0]  y_sel;
    logic               unused_frac;

    assign cur_mode = pe_mode_e'(mode_in);
    assign coefs    = coef_for(cur_mode);
    assign filt     = is_filtering(cur_mode);
    assign clr      = (mode_in != last_mode);

    // Select history: zero on a mode change.
    always_comb begin
        s1_use = clr ? '0 : s1_q;
        y1_use = clr ? '0 : y1_q;
    end

    assign p0 = $signed(s_in)   * $signed(coefs.b0);
    assign p1 = $signed(s1_use) * $signed(coefs.b1);
    assign p2 = $signed(y1_use) * $signed(coefs.fb);

    assign acc = $signed({{2{p0[PROD_W-1]}}, p0})
               + $signed({{2{p1[PROD_W-1]}}, p1})
               + $signed({{2{p2[PROD_W-1]}}, p2});

    assign unused_frac = ^acc[COEF_FRAC-1:0];

    aux_preemph_sat #(
        .IN_W  (SH_W),
        .OUT_W (DATA_W)
    ) u_sat (
        .din  (acc[ACC_W-1:COEF_FRAC]),
        .dout (y_lim)
    );

    // Output select: the limited filter result, or the scaled pass-through.
    assign y_sel = filt ? y_lim : s_in;

    // Strobe pipeline: second cycle of delay for the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) v_out <= 1'b0;
        else        v_out <= v_in;
    end

    // Result and history update on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_out     <= '0;
            s1_q      <= '0;
            y1_q      <= '0;
            last_mode <= 2'b00;
        end else if (v_in) begin
            y_out     <= y_sel;
            s1_q      <= s_in;
            y1_q      <= y_sel;
            last_mode <= mode_in;
        end
    end

    // R4: a positive overshoot clamps to the maximum code.
    // R4
    clip_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_in && filt && !acc[ACC_W-1] && (acc[ACC_W-1:COEF_FRAC] > SH_W'(MAXV)))
        |=> ($signed(y_out) == MAXV));

    // R4: a negative overshoot clamps to the minimum code.
    // R4
    clip_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_in && filt && acc[ACC_W-1] &&
         ($signed(acc[ACC_W-1:COEF_FRAC]) < $signed({{(SH_W-DATA_W){1'b1}}, MINV})))
        |=> ($signed(y_out) == MINV));

    // R5: the off modes pass the scaled sample straight through.
    // R5
    off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_in && !filt) |=> (y_out == $past(s_in)));

    // R7: after a strobe, the stored mode equals that sample's mode.
    // R7
    mode_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_in |=> (last_mode == $past(mode_in)));

endmodule

// File: rtl/aux_preemph.sv
// Top: auxiliary-channel preemphasis. The right channel is scaled by about
// -3 dB, filtered by the selected shelving IIR and limited; the left
// channel is delayed to match. The latency is two cycles from in_valid to
// out_valid. Assumes at most one strobe per cycle, which is always true.
module aux_preemph #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_left,
    input  logic [DATA_W-1:0] in_right,
    input  logic [1:0]        mode,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right
);
    logic              st1_valid;
    logic [DATA_W-1:0] st1_left;
    logic [DATA_W-1:0] st1_scaled;
    logic [1:0]        st1_mode;

    aux_preemph_scale #(
        .DATA_W    (DATA_W),
        .GAIN_W    (16),
        .GAIN      (23170),
        .GAIN_FRAC (15)
    ) u_scale (
        .clk      (clk),
        .rst_n    (rst_n),
        .v_in     (in_valid),
        .x_left   (in_left),
        .x_right  (in_right),
        .mode_in  (mode),
        .v_out    (st1_valid),
        .left_out (st1_left),
        .s_out    (st1_scaled),
        .mode_out (st1_mode)
    );

    aux_preemph_iir #(
        .DATA_W (DATA_W)
    ) u_iir (
        .clk     (clk),
        .rst_n   (rst_n),
        .v_in    (st1_valid),
        .s_in    (st1_scaled),
        .mode_in (st1_mode),
        .v_out   (out_valid),
        .y_out   (out_right)
    );

    // Left alignment register: matches the second pipeline stage.
    always_ff @(posedge clk) begin
        if (!rst_n)         out_left <= '0;
        else if (st1_valid) out_left <= st1_left;
    end

    // R8
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    // R8
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    // R6
    left_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_left == $past(in_left, 2)));

endmodule

// File: tb/aux_preemph_tb.sv
module aux_preemph_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC = 22;

    // Stimulus vectors {mode, left, right}; the expected right outputs come
    // from the requirement equations below, and left is expected unchanged.
    localparam logic [33:0] VEC [N_VEC] = '{
        {2'b00, 16'h1234, 16'(1)},
        {2'b00, 16'h8000, 16'(-1)},
        {2'b00, 16'h7FFF, 16'(10000)},
        {2'b01, 16'h0001, 16'(10000)},
        {2'b01, 16'h0002, 16'(10000)},
        {2'b01, 16'h0003, 16'(10000)},
        {2'b01, 16'h0004, 16'(-5000)},
        {2'b01, 16'hFFFF, 16'(-5000)},
        {2'b10, 16'h0005, 16'(-5000)},
        {2'b10, 16'h0006, 16'(-5000)},
        {2'b10, 16'h0007, 16'(12000)},
        {2'b10, 16'h0008, 16'(0)},
        {2'b11, 16'h0009, 16'(3000)},
        {2'b11, 16'h000A, 16'(-3000)},
        {2'b01, 16'h000B, 16'(32767)},
        {2'b01, 16'h000C, 16'(32767)},
        {2'b01, 16'h000D, 16'(-32768)},
        {2'b10, 16'h000E, 16'(-32768)},
        {2'b10, 16'h000F, 16'(-32768)},
        {2'b10, 16'h0010, 16'(32767)},
        {2'b00, 16'h0011, 16'(-32768)},
        {2'b00, 16'h0012, 16'(32767)}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_left = '0;
    logic [15:0] in_right = '0;
    logic [1:0]  mode = 2'b00;
    logic        out_valid;
    logic [15:0] out_left;
    logic [15:0] out_right;

    int checks = 0;
    int errors = 0;

    // Reference model state, built from R2, R3, R5 and R7.
    int m_s1 = 0, m_y1 = 0, m_last = 0;
    bit m_clr_flag;
    int exp_r [N_VEC];
    int exp_l [N_VEC];
    string exp_tag [N_VEC];

    always #(CLK_PERIOD/2) clk = ~clk;

    aux_preemph u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_left   (in_left),
        .in_right  (in_right),
        .mode      (mode),
        .out_valid (out_valid),
        .out_left  (out_left),
        .out_right (out_right)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int sat16(input longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    // Runs one sample through the model; returns the expected right output.
    function automatic int model(input int m, input int x);
        int s, s1, y1, y;
        longint acc;
        longint b0, b1, f;
        s = (x * 23170) >>> 15;
        m_clr_flag = (m != m_last);
        s1 = m_clr_flag ? 0 : m_s1;
        y1 = m_clr_flag ? 0 : m_y1;
        case (m)
            1: begin b0 = 31249; b1 = -20599; f = 5734; end
            2: begin b0 = 30403; b1 = -23030; f = 9011; end
            default: begin b0 = 0; b1 = 0; f = 0; end
        endcase
        if (m == 1 || m == 2) begin
            acc = b0 * s + b1 * s1 + f * y1;
            y = sat16(acc >>> 14);
        end else begin
            y = s;
        end
        m_s1 = s;
        m_y1 = y;
        m_last = m;
        return y;
    endfunction

    function automatic void model_reset();
        m_s1 = 0; m_y1 = 0; m_last = 0;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        model_reset();
        chk("R9 out_valid in reset", int'(out_valid), 0);
        chk("R9 out_left in reset", int'($signed(out_left)), 0);
        chk("R9 out_right in reset", int'($signed(out_right)), 0);
        rst_n = 1'b1;
    endtask

    // Sends one isolated sample and checks the strobe timing and the data.
    task automatic single(input int m, input int l, input int r, input string tag);
        int e;
        e = model(m, r);
        @(negedge clk);
        in_valid = 1'b1; mode = 2'(m); in_left = 16'(l); in_right = 16'(r);
        @(negedge clk);
        in_valid = 1'b0; in_right = 16'h5A5A; in_left = 16'hA5A5; mode = 2'(3 - m);
        chk("R8 no strobe after one cycle", int'(out_valid), 0);
        @(negedge clk);
        chk("R8 strobe after two cycles", int'(out_valid), 1);
        chk(tag, int'($signed(out_right)), e);
        chk("R6 left passthrough", int'($signed(out_left)), int'($signed(16'(l))));
        @(negedge clk);
        chk("R8 single-cycle strobe", int'(out_valid), 0);
        chk("R8 right output held", int'($signed(out_right)), e);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();

        // Vector table, driven back to back with one strobe per cycle.
        for (int i = 0; i < N_VEC + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                chk("R8 burst strobe", int'(out_valid), 1);
                chk("R6 burst left", int'($signed(out_left)), exp_l[i-2]);
                chk(exp_tag[i-2], int'($signed(out_right)), exp_r[i-2]);
            end
            if (i < N_VEC) begin
                int m, l, r;
                m = int'(VEC[i][33:32]);
                l = int'($signed(VEC[i][31:16]));
                r = int'($signed(VEC[i][15:0]));
                exp_r[i] = model(m, r);
                exp_l[i] = l;
                if (m_clr_flag && (m == 1 || m == 2))
                    exp_tag[i] = "R7 cleared-history right";
                else if (m == 3)
                    exp_tag[i] = "R1 reserved mode as off";
                else if (m == 0)
                    exp_tag[i] = "R5 off-mode right (R2 scale)";
                else
                    exp_tag[i] = "R3 filtered right (R4 limit)";
                in_valid = 1'b1; mode = 2'(m);
                in_left = 16'(l); in_right = 16'(r);
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk("R8 strobe ends after burst", int'(out_valid), 0);

        // Directed: scaling corner values in the off mode.
        single(0, 100, -1, "R2 scale of -1");
        single(0, 101, 1, "R2 scale of +1");
        single(0, 102, -32768, "R2 scale of min");

        // Directed: full-scale steps after a mode change clip without wrap.
        single(1, 200, 32767, "R4 positive clip");
        chk("R4 positive clip value", int'($signed(out_right)), 32767);
        single(2, 201, -32768, "R4 negative clip");
        chk("R4 negative clip value", int'($signed(out_right)), -32768);

        // Directed: a history clear on a mode change, then the filter continues.
        single(1, 300, 8000, "R7 clear on switch to 50us");
        single(1, 301, 8000, "R3 50us second sample");
        single(2, 302, 8000, "R7 clear on switch to 75us");
        single(2, 303, 8000, "R3 75us second sample");

        // Reset in mid-stream clears the history and the mode memory.
        do_reset();
        single(1, 400, 6000, "R9 history cleared by reset");
        single(0, 401, 6000, "R5 off after reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule